// File: doc/BRIEF.md
# Address-Triggered Phase Restart Pulse

This block watches a serial peripheral bus and raises a one-cycle restart strobe in the system clock domain when a transaction opens with one reserved address byte. Two chips that share the bus can each hold a copy of this block. A single bus write then restarts the excitation waveforms on one side and the down-mixing waveforms on the other on the same command. The host issues that write at the start of every measurement cycle, so both sides begin the cycle in phase.

The bus side runs in mode 0. Bits are sampled on the rising serial clock, most significant bit first, and the first byte after chip select falls is the address. Once the eighth address bit has been captured, a match flag is set if the byte equals the reserved value. The flag is cleared as soon as chip select rises again. The system clock side passes the flag through a chain of synchronizing flops. A rising-edge stage then turns the synchronized level into a registered pulse that lasts exactly one system clock cycle. The waveform generators and any handling of the payload sit outside this block.

Top module: `phase_align_trigger`

## Requirements
- R1: While `rst` is high, and in the cycle that follows it, `phase_rst_o` is low.
- R2: A transaction whose first byte equals `MATCH_ADDR` produces exactly one pulse on `phase_rst_o`. The byte is sampled on rising `spi_sclk` while `spi_cs_n` is low, with bit 7 first.
- R3: Every pulse on `phase_rst_o` is high for exactly one `clk` cycle.
- R4: With the default two synchronizer stages, the pulse is high at the latest 4 `clk` cycles after the rising `spi_sclk` edge that samples the eighth address bit.
- R5: A first byte that differs from `MATCH_ADDR` in any bit, including only the top bit or only the bottom bit, produces no pulse.
- R6: A matching address followed by further bytes in the same transaction still produces exactly one pulse.
- R7: Only the first byte after `spi_cs_n` falls is compared. A later byte equal to `MATCH_ADDR` produces no pulse.
- R8: A transaction that ends with fewer than 8 bits clocked produces no pulse, even if those bits agree with `MATCH_ADDR`.
- R9: Raising `spi_cs_n` clears the match, so a second matching transaction produces a second pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| spi_sclk | input | 1 | Serial bus clock, mode 0 |
| spi_cs_n | input | 1 | Serial bus select, active low; high clears the capture logic |
| spi_mosi | input | 1 | Serial data into the block |
| phase_rst_o | output | 1 | One-cycle phase restart strobe, registered |

## Verification
The bench builds the block with an 8-bit address, `MATCH_ADDR` set to 8'h5A and two synchronizer stages. This address lets the bench reach the comparator's top and bottom bits with the single-bit neighbours 8'hDA and 8'h5B. The two-stage chain gives a fixed latency bound that the bench measures from the eighth serial clock edge. The serial clock runs well below the system clock and its edges fall at times away from the system clock edges. Pulse counts are therefore exact, both for payloads that contain the address byte and for transactions that stop short of eight bits.

// File: rtl/phase_trig_pkg.sv
package phase_trig_pkg;
  localparam int unsigned DEF_ADDR_W      = 8;
  localparam logic [7:0]  DEF_MATCH_ADDR  = 8'h5A;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    CAP_ADDR    = 1'b0,
    CAP_PAYLOAD = 1'b1
  } cap_phase_e;
endpackage

// File: rtl/spi_addr_capture.sv
module spi_addr_capture
  import phase_trig_pkg::*;
#(
  parameter int unsigned        ADDR_W     = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0]  MATCH_ADDR = ADDR_W'(DEF_MATCH_ADDR)
) (
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic match_o
);
  localparam int unsigned CNT_W    = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W - 1);

  logic [ADDR_W-2:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  cap_phase_e        phase;

  // Select high holds the capture logic cleared; bits after the address byte are ignored.
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      phase   <= CAP_ADDR;
      match_o <= 1'b0;
    end else if (phase == CAP_ADDR) begin
      shreg <= {shreg[ADDR_W-3:0], mosi};
      if (bit_cnt == LAST_BIT) begin
        phase   <= CAP_PAYLOAD;
        match_o <= ({shreg, mosi} == MATCH_ADDR);
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/level_sync.sv
module level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      lvl_q   <= lvl;
      pulse_o <= lvl & ~lvl_q;
    end
  end
endmodule

// File: rtl/phase_align_trigger.sv
module phase_align_trigger
  import phase_trig_pkg::*;
#(
  parameter int unsigned       ADDR_W      = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] MATCH_ADDR  = ADDR_W'(DEF_MATCH_ADDR),
  parameter int unsigned       SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic phase_rst_o
);
  logic addr_hit;
  logic sync_lvl;

  spi_addr_capture #(
    .ADDR_W     (ADDR_W),
    .MATCH_ADDR (MATCH_ADDR)
  ) u_cap (
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .match_o (addr_hit)
  );

  level_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (addr_hit),
    .q   (sync_lvl)
  );

  rise_pulse u_edge (
    .clk     (clk),
    .rst     (rst),
    .lvl     (sync_lvl),
    .pulse_o (phase_rst_o)
  );
endmodule

// File: rtl/phase_align_trigger_chk.sv
module phase_align_trigger_chk (
  input logic clk,
  input logic rst,
  input logic sync_lvl,
  input logic pulse
);
  logic rst_q = 1'b0;

  always @(posedge clk) begin
    // R1
    if (rst_q) begin
      reset_quiet_chk: assert (!pulse) else $error("strobe high after reset cycle");
    end
    rst_q <= rst;
  end

  // R3
  one_cycle_wide_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R2
  pulse_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(sync_lvl));

  // R9
  rise_gives_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_lvl) |=> pulse);

  // R5
  low_level_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_lvl) |=> !pulse);
endmodule

bind phase_align_trigger phase_align_trigger_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sync_lvl (sync_lvl),
  .pulse    (phase_rst_o)
);

// File: tb/tb_phase_align_trigger.sv
`timescale 1ns/1ps
module tb_phase_align_trigger;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic phase_rst_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    pulses   = 0;
  int    wide_cnt = 0;
  logic  prev_hi  = 1'b0;
  bit    done     = 1'b0;
  realtime rise8_t = 0.0;
  realtime pulse_t = 0.0;

  always #4 clk = ~clk;

  phase_align_trigger #(
    .ADDR_W      (8),
    .MATCH_ADDR  (8'h5A),
    .SYNC_STAGES (2)
  ) dut (
    .clk         (clk),
    .rst         (rst),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi),
    .phase_rst_o (phase_rst_o)
  );

  always @(negedge clk) begin
    if (phase_rst_o === 1'b1) begin
      pulses  = pulses + 1;
      pulse_t = $realtime;
      if (prev_hi) wide_cnt = wide_cnt + 1;
    end
    prev_hi = (phase_rst_o === 1'b1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Sends nbits of bits, starting at bit 31, in mode 0.
  task automatic xact(input logic [31:0] bits, input int nbits);
    @(negedge clk); #1;
    spi_cs_n = 1'b0;
    #20;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = bits[31-i];
      #20;
      spi_sclk = 1'b1;
      if (i == 7) rise8_t = $realtime;
      #20;
      spi_sclk = 1'b0;
    end
    #20;
    spi_cs_n = 1'b1;
    #100;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    check(phase_rst_o === 1'b0, "R1", int'(phase_rst_o), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(phase_rst_o === 1'b0, "R1", int'(phase_rst_o), 0);
    check(pulses == 0, "R1", pulses, 0);
  endtask

  task automatic t_match;
    int p0 = pulses;
    int w0 = wide_cnt;
    xact({8'h5A, 24'h0}, 8);
    check(pulses - p0 == 1, "R2", pulses - p0, 1);
    check(wide_cnt == w0, "R3", wide_cnt - w0, 0);
    check(pulse_t > rise8_t && (pulse_t - rise8_t) <= 36.0, "R4",
          int'(pulse_t - rise8_t), 36);
  endtask

  task automatic t_miss(input logic [7:0] a);
    int p0 = pulses;
    xact({a, 24'h0}, 8);
    check(pulses == p0, "R5", pulses - p0, 0);
  endtask

  task automatic t_payload;
    int p0 = pulses;
    xact({8'h5A, 8'h5A, 8'hFF, 8'h5A}, 32);
    check(pulses - p0 == 1, "R6", pulses - p0, 1);
    check(wide_cnt == 0, "R3", wide_cnt, 0);
  endtask

  task automatic t_late_byte;
    int p0 = pulses;
    xact({8'h33, 8'h5A, 8'h5A, 8'h00}, 32);
    check(pulses == p0, "R7", pulses - p0, 0);
  endtask

  task automatic t_short;
    int p0 = pulses;
    xact({8'h5A, 24'h0}, 7);
    check(pulses == p0, "R8", pulses - p0, 0);
    // The next full match must still work after an aborted transfer.
    xact({8'h5A, 24'h0}, 8);
    check(pulses - p0 == 1, "R8", pulses - p0, 1);
  endtask

  task automatic t_back_to_back;
    int p0 = pulses;
    xact({8'h5A, 24'h0}, 8);
    xact({8'h5A, 8'h01, 16'h0}, 16);
    check(pulses - p0 == 2, "R9", pulses - p0, 2);
    check(wide_cnt == 0, "R3", wide_cnt, 0);
  endtask

  initial begin
    #1200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_match();
    t_miss(8'hDA);
    t_miss(8'h5B);
    t_miss(8'hA5);
    t_payload();
    t_late_byte();
    t_short();
    t_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule